// File: doc/BRIEF.md
# Peripheral Clock-Enable Divider with Two Gates

This block turns one of three incoming clock-enable streams into a slower enable stream for peripherals. Everything runs in one system clock domain. Each source is a single-cycle strobe on `src_tick`. A 32-bit control word chooses the source and an integer divisor. The divided strobe then goes out on up to two gated outputs. Each output has its own enable bit in the same control word.

Software, or a neighbouring block, writes the control word through a one-cycle write strobe and can read it back at any time. The second gated output is present only when the `HAS_B` parameter is set. Without it, the second gate bit is not stored and has no effect. When the source or the divisor changes, the divide count starts over. This prevents a short first period under the new setting.

Top module: `periph_clkgen`

## Requirements
- R1: After reset the control word reads 0x0000_0100 (source code 0, divisor 1, both gates off) and both gated outputs are low.
- R2: After a write, `rd_data` equals the written word ANDed with 0x0000_3F33 (0x0000_3F31 when `HAS_B` is 0). Bits 0 and 1 are the gate enables, bits 5:4 the source code and bits 13:8 the divisor. Every other bit reads zero.
- R3: Source codes 0 and 1 both pick `src_tick[0]`, code 2 picks `src_tick[1]`, and code 3 picks `src_tick[2]`.
- R4: With divisor N, an enabled output pulses high for one cycle on every Nth strobe of the selected source. The pulse appears in the cycle after that strobe.
- R5: A divisor of 0 behaves like 1: every selected strobe passes to the enabled outputs.
- R6: Bit 0 enables `tick_a` and bit 1 enables `tick_b`, independently. A disabled output stays low.
- R7: A write that changes the source code or the divisor field restarts the count. The first pulse after it follows the Nth selected strobe after the write.
- R8: A write that leaves both the source code and the divisor unchanged does not disturb the count in progress.
- R9: With `HAS_B` = 0, bit 1 reads zero and `tick_b` stays low whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 3 | Source clock-enable strobes, one bit per source |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word, unused bits zero |
| tick_a | output | 1 | First gated divided strobe |
| tick_b | output | 1 | Second gated divided strobe (held low without `HAS_B`) |

## Verification
The assertions assume that `src_tick` and `wr_en` are never unknown after reset. They also assume that a write and a source strobe may arrive together, in which case the old setting decides that cycle's pulse. The stimulus keeps away from that overlap. Sources are stopped before every write and started again only afterwards. Every window ends with idle cycles, so each expected pulse count covers a whole run and does not depend on where the counter sat when a write landed.

// File: rtl/periph_clkgen.sv
module periph_clkgen #(
  parameter int REG_W  = 32,
  parameter int DIV_W  = 6,
  parameter int SRC_N  = 3,
  parameter bit HAS_B  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_tick,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             tick_a,
  output logic             tick_b
);
  localparam int GA_BIT  = 0;
  localparam int GB_BIT  = 1;
  localparam int SEL_LSB = 4;
  localparam int SEL_W   = 2;
  localparam int DIV_LSB = 8;
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  logic             gate_a_q;
  logic             gate_b_q;
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic             tick_a_q;

  wire [SEL_W-1:0] sel_new = wr_data[SEL_LSB +: SEL_W];
  wire [DIV_W-1:0] div_new = wr_data[DIV_LSB +: DIV_W];

  wire src_pick = (sel_q == 2'd3) ? src_tick[2] :
                  (sel_q == 2'd2) ? src_tick[1] : src_tick[0];

  wire [DIV_W-1:0] last_cnt = (div_q == '0) ? '0 : div_q - DIV_ONE;
  wire             at_last  = (cnt_q == last_cnt);
  wire             restart  = wr_en && ((sel_new != sel_q) || (div_new != div_q));
  wire             fire     = src_pick && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_a_q <= 1'b0;
      sel_q    <= '0;
      div_q    <= DIV_ONE;
    end else if (wr_en) begin
      gate_a_q <= wr_data[GA_BIT];
      sel_q    <= sel_new;
      div_q    <= div_new;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (restart)    cnt_q <= '0;
    else if (src_pick)   cnt_q <= at_last ? '0 : cnt_q + DIV_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tick_a_q <= 1'b0;
    else        tick_a_q <= fire && gate_a_q;
  end

  generate
    if (HAS_B) begin : g_gate_b
      logic tick_b_q;
      always_ff @(posedge clk) begin
        if (!rst_n)     gate_b_q <= 1'b0;
        else if (wr_en) gate_b_q <= wr_data[GB_BIT];
      end
      always_ff @(posedge clk) begin
        if (!rst_n) tick_b_q <= 1'b0;
        else        tick_b_q <= fire && gate_b_q;
      end
      assign tick_b = tick_b_q;
    end else begin : g_no_gate_b
      assign gate_b_q = 1'b0;
      assign tick_b   = 1'b0;
    end
  endgenerate

  assign tick_a = tick_a_q;

  always_comb begin
    rd_data                          = '0;
    rd_data[GA_BIT]                  = gate_a_q;
    rd_data[GB_BIT]                  = gate_b_q;
    rd_data[SEL_LSB +: SEL_W]        = sel_q;
    rd_data[DIV_LSB +: DIV_W]        = div_q;
  end
endmodule

// File: rtl/periph_clkgen_chk.sv
module periph_clkgen_chk #(
  parameter bit HAS_B = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  src_tick,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        tick_a,
  input logic        tick_b
);
  localparam logic [31:0] MASK = HAS_B ? 32'h0000_3F33 : 32'h0000_3F31;

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~MASK) == 32'h0) else $error("unused bits set"); // R2

  AST_WRITE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & MASK)) else $error("readback mismatch"); // R2

  AST_GATE_A_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] |=> !tick_a) else $error("tick_a while gated"); // R6

  AST_GATE_B_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[1] |=> !tick_b) else $error("tick_b while gated"); // R6

  AST_B_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_B |-> (!tick_b && !rd_data[1])) else $error("absent gate active"); // R9

  AST_TICK_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !(|src_tick) |=> (!tick_a && !tick_b)) else $error("tick with no source"); // R4

  AST_DIV_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[13:8] <= 6'd1 && rd_data[5:4] < 2'd2 && src_tick[0] && rd_data[0])
      |=> tick_a) else $error("pass-through missed"); // R5
endmodule

bind periph_clkgen periph_clkgen_chk #(.HAS_B(HAS_B)) chk_i (
  .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .tick_a(tick_a), .tick_b(tick_b)
);

// File: tb/periph_clkgen_tb_top.sv
module periph_clkgen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_tick = '0;
  logic        wr_en = 1'b0, wr_en_s = 1'b0;
  logic [31:0] wr_data = '0, wr_data_s = '0;
  logic [31:0] rd_data, rd_data_s;
  logic        tick_a, tick_b, tick_a_s, tick_b_s;

  int errors = 0;
  int checks = 0;
  int cnt_a = 0, cnt_b = 0, cnt_as = 0, cnt_bs = 0;

  localparam logic [31:0] JUNK = 32'hFFFF_C0CC;
  localparam int NV = 8;
  localparam logic [31:0] VCFG [NV] = '{32'h0103, 32'h0311, 32'h0422, 32'h0533,
                                        32'h0023, 32'h3F33, 32'h0703, 32'h0130};
  localparam int VEXP_A [NV] = '{60, 20, 0, 4, 30, 0, 8, 0};
  localparam int VEXP_B [NV] = '{60, 0, 7, 4, 30, 0, 8, 0};

  always #10 clk = ~clk;

  periph_clkgen dut_i (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tick_a(tick_a), .tick_b(tick_b));

  periph_clkgen #(.HAS_B(1'b0)) u_single (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en_s),
    .wr_data(wr_data_s), .rd_data(rd_data_s), .tick_a(tick_a_s), .tick_b(tick_b_s));

  always @(negedge clk) begin
    cnt_a  = cnt_a  + int'(tick_a);
    cnt_b  = cnt_b  + int'(tick_b);
    cnt_as = cnt_as + int'(tick_a_s);
    cnt_bs = cnt_bs + int'(tick_b_s);
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    cnt_a = 0; cnt_b = 0; cnt_as = 0; cnt_bs = 0;
  endtask

  task automatic write_main(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic write_single(input logic [31:0] v);
    @(negedge clk); wr_en_s = 1'b1; wr_data_s = v;
    @(negedge clk); wr_en_s = 1'b0;
  endtask

  // src0 every cycle, src1 every 2nd, src2 every 3rd; then idle to drain
  task automatic run(input int n);
    for (int ph = 0; ph < n; ph++) begin
      @(negedge clk);
      src_tick[0] = 1'b1;
      src_tick[1] = (ph % 2) == 0;
      src_tick[2] = (ph % 3) == 0;
    end
    @(negedge clk); src_tick = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset word", rd_data, 32'h0000_0100);
    check("R1 reset tick_a", tick_a, 0);
    check("R1 reset tick_b", tick_b, 0);
    clear_counts();

    for (int v = 0; v < NV; v++) begin
      write_main(VCFG[v] | JUNK);
      check("R2 readback", rd_data, VCFG[v]);
      clear_counts();
      run(60);
      check("R3 R4 R5 R6 tick_a count", cnt_a, VEXP_A[v]);
      check("R3 R4 R5 R6 tick_b count", cnt_b, VEXP_B[v]);
    end

    write_main(32'h0403);
    clear_counts(); run(2);
    check("R4 below divisor", cnt_a, 0);
    write_main(32'h0303);
    clear_counts(); run(1);
    check("R7 restart no early pulse", cnt_a, 0);
    run(2);
    check("R7 pulse on third strobe", cnt_a, 1);

    clear_counts(); run(2);
    check("R8 partial count", cnt_a + cnt_b, 0);
    write_main(32'h0302);
    clear_counts(); run(1);
    check("R8 count kept tick_b", cnt_b, 1);
    check("R8 R6 tick_a gated off", cnt_a, 0);

    write_single(32'h0103 | JUNK);
    check("R9 single readback", rd_data_s, 32'h0000_0101);
    clear_counts(); run(60);
    check("R9 single tick_a", cnt_as, 60);
    check("R9 single tick_b low", cnt_bs, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule